// File: doc/BRIEF.md
# Byte-Lane Memory Access Sequencer

This block sits between a processor's data path and a 16-bit, byte-addressed memory bus. It takes one request at a time, made of a segment, an offset, a size flag (byte or word), a direction flag and write data. It forms a 20-bit physical address, works out how many bus cycles the access needs, and runs those cycles. For each cycle it drives the byte enables and places the write bytes on the correct lanes. For reads it collects the bytes from the correct lanes.

A word whose first byte sits at an even address takes one bus cycle. A word at an odd address takes two cycles, with the bytes swapped between lanes. Byte accesses use the lane chosen by address bit 0. The memory ends each cycle by raising a ready input, and a cycle lasts as long as ready stays low. When the last cycle has finished, the block gives the requester a one-cycle done pulse and the assembled read data.

The request side uses a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. While an access is in progress the block applies back-pressure by holding `req_ready` low, and the requester must keep or repeat its request until it is taken. The response is a plain pulse with no back-pressure, so the requester must take it in the cycle it appears.

Top module: `mem_lane_seq`

## Requirements
- R1: The physical address is the segment shifted left by four bits plus the offset, computed modulo 2^20.
- R2: A word access at an even physical address P runs exactly one bus cycle, with `bus_addr` = P and `bus_be` = 2'b11. A read returns `bus_rdata` unchanged.
- R3: A word access at an odd physical address P runs two bus cycles. The first uses `bus_addr` = P-1 and `bus_be` = 2'b10. The second uses `bus_addr` = (P-1)+2 modulo 2^20 and `bus_be` = 2'b01. A read returns the high-lane byte of the first cycle in bits [7:0] and the low-lane byte of the second cycle in bits [15:8].
- R4: A byte access at physical address P runs one bus cycle, with `bus_addr` = P with bit 0 cleared. `bus_be` is 2'b01 when P is even and 2'b10 when P is odd. A read returns the selected lane's byte in bits [7:0] with bits [15:8] zero, so the other lane has no effect on the result.
- R5: In write cycles `bus_we` is high and each enabled lane carries its data byte. Even byte: data[7:0] goes on lane [7:0]. Odd byte: data[7:0] goes on lane [15:8]. Even word: data as given. Odd word: data[7:0] goes on lane [15:8] in the first cycle, and data[15:8] goes on lane [7:0] in the second. Read cycles keep `bus_we` low.
- R6: A bus cycle ends only on a rising edge where `bus_ready` is high. Until then `bus_addr`, `bus_be`, `bus_we` and `bus_wdata` hold steady. From acceptance to the done pulse takes (number of bus cycles + cycles with ready low) clock cycles, and the pulse appears one cycle after the final ready edge.
- R7: Each accepted request gives exactly one `rsp_valid` pulse, one cycle long, and only after its last bus cycle has finished.
- R8: `req_ready` is low whenever a bus cycle is in progress, so no second request is taken before the first completes.
- R9: Address formation and the second-cycle address wrap at 2^20. Segment 16'hFFFF with offset 16'h0020 gives 20'h00010, and an odd word at 20'hFFFFF ends at address 20'h00000.
- R10: After reset, `req_ready` is high, `bus_cyc` is low and `rsp_valid` is low. A write returns `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request is taken this edge |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within segment |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte access uses bits [7:0]) |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 16 | Read result, zero for writes |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Even-aligned bus address |
| bus_be | output | 2 | Byte enables: bit 0 = lane [7:0], bit 1 = lane [15:8] |
| bus_wdata | output | 16 | Write data, by lane |
| bus_rdata | input | 16 | Read data, by lane |
| bus_ready | input | 1 | Memory completes the current cycle |

## Verification
The first bus cycle is visible in the clock cycle after the request is taken. Each later cycle starts in the clock cycle after the previous cycle's ready edge, and `rsp_valid` with its data comes one cycle after the final ready edge. The bench drives inputs and samples outputs on the falling edge. Its memory model records each cycle at the falling edge where it raises ready. It counts the wait cycles it injects and compares the latency from acceptance to `rsp_valid` with the cycle count plus the waits. It checks that `rsp_valid` is low again one cycle later.

// File: rtl/mls_pkg.sv
package mls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC1 = 2'd1,
    ST_CYC2 = 2'd2
  } seq_state_e;

  localparam logic [1:0] BE_LO   = 2'b01;
  localparam logic [1:0] BE_HI   = 2'b10;
  localparam logic [1:0] BE_BOTH = 2'b11;

endpackage

// File: rtl/mls_addr_gen.sv
module mls_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);

  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;

  // Both terms are truncated to the address width, so the sum wraps.
  assign seg_ext = ADDR_W'(seg) << SEG_SHIFT;
  assign off_ext = ADDR_W'(off);
  assign phys    = seg_ext + off_ext;

endmodule

// File: rtl/mls_lane_steer.sv
module mls_lane_steer
  import mls_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                phase2,
  input  logic                is_word,
  input  logic                odd,
  input  logic [2*LANE_W-1:0] wdata,
  input  logic [2*LANE_W-1:0] bus_rdata,
  input  logic [LANE_W-1:0]   held_lo,
  output logic [1:0]          be,
  output logic [2*LANE_W-1:0] bus_wdata,
  output logic [LANE_W-1:0]   first_byte,
  output logic [2*LANE_W-1:0] final_rdata
);

  localparam int NLANE = 2;

  logic [LANE_W-1:0] rd_lane [NLANE];
  logic [LANE_W-1:0] wd_lo;
  logic [LANE_W-1:0] wd_hi;
  logic [LANE_W-1:0] zero_b;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign rd_lane[g] = bus_rdata[g*LANE_W +: LANE_W];
  end

  assign wd_lo  = wdata[LANE_W-1:0];
  assign wd_hi  = wdata[2*LANE_W-1:LANE_W];
  assign zero_b = '0;

  // Lane enables for the current cycle.
  always_comb begin
    if (!is_word)      be = odd ? BE_HI : BE_LO;
    else if (!odd)     be = BE_BOTH;
    else               be = phase2 ? BE_LO : BE_HI;
  end

  // Write data is placed on its lane; unused lanes carry zero.
  always_comb begin
    if (!is_word)      bus_wdata = odd ? {wd_lo, zero_b} : {zero_b, wd_lo};
    else if (!odd)     bus_wdata = wdata;
    else               bus_wdata = phase2 ? {zero_b, wd_hi} : {wd_lo, zero_b};
  end

  // In a split read, the first cycle keeps the high lane.
  assign first_byte = rd_lane[1];

  always_comb begin
    if (!is_word)      final_rdata = {zero_b, (odd ? rd_lane[1] : rd_lane[0])};
    else if (!odd)     final_rdata = bus_rdata;
    else               final_rdata = {rd_lane[0], held_lo};
  end

endmodule

// File: rtl/mls_ctrl.sv
module mls_ctrl
  import mls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   in_phys,
  input  logic                in_word,
  input  logic                in_write,
  input  logic [2*LANE_W-1:0] in_wdata,
  input  logic                bus_ready,
  input  logic [LANE_W-1:0]   first_byte,
  input  logic [2*LANE_W-1:0] final_rdata,
  input  logic [1:0]          bus_be,
  input  logic [2*LANE_W-1:0] bus_wdata,
  output logic                bus_cyc,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                phase2,
  output logic                word_q,
  output logic                odd_q,
  output logic [2*LANE_W-1:0] wdata_q,
  output logic [LANE_W-1:0]   held_lo,
  output logic                rsp_valid,
  output logic [2*LANE_W-1:0] rsp_rdata
);

  localparam int DATA_W = 2 * LANE_W;

  seq_state_e        st_q;
  logic [ADDR_W-1:0] phys_q;
  logic              write_q;
  logic              split;
  logic              last_cyc;
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] next_addr;

  assign odd_q     = phys_q[0];
  assign split     = word_q & odd_q;
  assign last_cyc  = (st_q == ST_CYC2) || !split;
  assign base_addr = {phys_q[ADDR_W-1:1], 1'b0};
  assign next_addr = base_addr + ADDR_W'(2);

  assign req_ready = (st_q == ST_IDLE);
  assign bus_cyc   = (st_q != ST_IDLE);
  assign phase2    = (st_q == ST_CYC2);
  assign bus_we    = bus_cyc & write_q;
  assign bus_addr  = phase2 ? next_addr : base_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      phys_q    <= '0;
      word_q    <= 1'b0;
      write_q   <= 1'b0;
      wdata_q   <= '0;
      held_lo   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            phys_q  <= in_phys;
            word_q  <= in_word;
            write_q <= in_write;
            wdata_q <= in_wdata;
            st_q    <= ST_CYC1;
          end
        end
        ST_CYC1, ST_CYC2: begin
          if (bus_ready) begin
            if (!last_cyc) begin
              held_lo <= first_byte;
              st_q    <= ST_CYC2;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= write_q ? DATA_W'(0) : final_rdata;
              st_q      <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !req_ready); // R8

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be)
                                 && $stable(bus_we) && $stable(bus_wdata))); // R6

  AST_DONE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(bus_cyc && bus_ready) && !bus_cyc)); // R7

  AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CYC1 && bus_ready && word_q && odd_q) |=> (bus_cyc && !rsp_valid)); // R3

endmodule

// File: rtl/mem_lane_seq.sv
module mem_lane_seq
  import mls_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20,
  parameter int LANE_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [SEG_W-1:0]    req_seg,
  input  logic [OFF_W-1:0]    req_off,
  input  logic                req_word,
  input  logic                req_write,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic                rsp_valid,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic                bus_cyc,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [1:0]          bus_be,
  output logic [2*LANE_W-1:0] bus_wdata,
  input  logic [2*LANE_W-1:0] bus_rdata,
  input  logic                bus_ready
);

  localparam int DATA_W = 2 * LANE_W;

  logic [ADDR_W-1:0] phys;
  logic              phase2;
  logic              word_q;
  logic              odd_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANE_W-1:0] held_lo;
  logic [LANE_W-1:0] first_byte;
  logic [DATA_W-1:0] final_rdata;

  mls_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
  ) addr_i (
    .seg (req_seg),
    .off (req_off),
    .phys(phys)
  );

  mls_ctrl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .in_phys    (phys),
    .in_word    (req_word),
    .in_write   (req_write),
    .in_wdata   (req_wdata),
    .bus_ready  (bus_ready),
    .first_byte (first_byte),
    .final_rdata(final_rdata),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_cyc    (bus_cyc),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .phase2     (phase2),
    .word_q     (word_q),
    .odd_q      (odd_q),
    .wdata_q    (wdata_q),
    .held_lo    (held_lo),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  mls_lane_steer #(.LANE_W(LANE_W)) steer_i (
    .phase2     (phase2),
    .is_word    (word_q),
    .odd        (odd_q),
    .wdata      (wdata_q),
    .bus_rdata  (bus_rdata),
    .held_lo    (held_lo),
    .be         (bus_be),
    .bus_wdata  (bus_wdata),
    .first_byte (first_byte),
    .final_rdata(final_rdata)
  );

  AST_EVEN_WORD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && word_q && !odd_q) |-> (bus_be == BE_BOTH)); // R2

  AST_SECOND_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && phase2 && !$past(phase2)) |-> (bus_addr == $past(bus_addr) + ADDR_W'(2))); // R3

  AST_ONE_LANE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !word_q) |-> ($countones(bus_be) == 1)); // R4

endmodule

// File: tb/mem_lane_seq_tb_top.sv
module mem_lane_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_seg = '0;
  logic [15:0] req_off = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        bus_cyc;
  logic        bus_we;
  logic [19:0] bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0]  mem [int unsigned];
  int          wcnt = 0;
  int          wait_tot = 0;
  int          n_log = 0;
  logic [19:0] log_addr [4];
  logic [1:0]  log_be [4];
  logic [15:0] log_wd [4];
  logic        log_we [4];
  logic [19:0] rsp_a;

  always #4 clk = ~clk;

  mem_lane_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  function automatic logic [7:0] rd_byte(input logic [19:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'(a * 7 + (a >> 8) * 13 + 20'h3C);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder: decides ready on the falling edge, records finished cycles.
  always @(negedge clk) begin
    if (!rst_n || !bus_cyc) begin
      bus_ready = 1'b0;
    end else if (wcnt == 0) begin
      bus_ready = 1'b1;
      rsp_a = bus_addr;
      bus_rdata = {rd_byte(rsp_a + 20'd1), rd_byte(rsp_a)};
      if (bus_we) begin
        if (bus_be[0]) mem[int'(rsp_a)] = bus_wdata[7:0];
        if (bus_be[1]) mem[int'(rsp_a + 20'd1)] = bus_wdata[15:8];
      end
      if (n_log < 4) begin
        log_addr[n_log] = bus_addr;
        log_be[n_log]   = bus_be;
        log_wd[n_log]   = bus_wdata;
        log_we[n_log]   = bus_we;
      end
      n_log++;
      wcnt = $urandom_range(0, 3);
    end else begin
      bus_ready = 1'b0;
      wcnt--;
      wait_tot++;
    end
  end

  task automatic do_req(input logic [15:0] seg, input logic [15:0] off,
                        input bit word, input bit write, input logic [15:0] wd);
    logic [19:0] ph, base;
    int          n_exp, cnt;
    logic [19:0] e_addr [2];
    logic [1:0]  e_be [2];
    logic [15:0] e_wd [2];
    logic [15:0] e_rd;
    bit          busy_ok;
    ph   = {seg, 4'h0} + {4'h0, off};
    base = {ph[19:1], 1'b0};
    if (!word) begin
      n_exp = 1; e_addr[0] = base;
      e_be[0] = ph[0] ? 2'b10 : 2'b01;
      e_wd[0] = ph[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
      e_rd = {8'h00, rd_byte(ph)};
    end else if (!ph[0]) begin
      n_exp = 1; e_addr[0] = base; e_be[0] = 2'b11; e_wd[0] = wd;
      e_rd = {rd_byte(ph + 20'd1), rd_byte(ph)};
    end else begin
      n_exp = 2;
      e_addr[0] = base;          e_be[0] = 2'b10; e_wd[0] = {wd[7:0], 8'h00};
      e_addr[1] = base + 20'd2;  e_be[1] = 2'b01; e_wd[1] = {8'h00, wd[15:8]};
      e_rd = {rd_byte(ph + 20'd1), rd_byte(ph)};
    end
    if (write) e_rd = 16'h0000;

    chk(req_ready === 1'b1, "R8 idle before request", {31'd0, req_ready}, 32'd1);
    req_seg = seg; req_off = off; req_word = word; req_write = write; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n_log = 0; wait_tot = 0; cnt = 0; busy_ok = 1;
    while (rsp_valid !== 1'b1 && cnt < 100) begin
      if (bus_cyc === 1'b1 && req_ready !== 1'b0) busy_ok = 0;
      @(negedge clk);
      cnt++;
    end
    chk(busy_ok, "R8 req_ready low while busy", {31'd0, busy_ok}, 32'd1);
    chk(rsp_valid === 1'b1, "R7 done pulse seen", {31'd0, rsp_valid}, 32'd1);
    chk(n_log == n_exp, "R2/R3 bus cycle count", n_log, n_exp);
    chk(cnt == n_exp + wait_tot, "R6 latency with waits", cnt, n_exp + wait_tot);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk(log_addr[i] == e_addr[i], "R1/R9 bus address", {12'd0, log_addr[i]}, {12'd0, e_addr[i]});
      chk(log_be[i] == e_be[i], "R4 byte enables", {30'd0, log_be[i]}, {30'd0, e_be[i]});
      chk(log_we[i] == write, "R5 bus_we", {31'd0, log_we[i]}, {31'd0, write});
      if (write)
        chk((log_wd[i] & {{8{e_be[i][1]}}, {8{e_be[i][0]}}}) == e_wd[i],
            "R5 write lane data", {16'd0, log_wd[i]}, {16'd0, e_wd[i]});
    end
    chk(rsp_rdata === e_rd, write ? "R10 write returns zero" : "R2/R3/R4 read data",
        {16'd0, rsp_rdata}, {16'd0, e_rd});
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R7 pulse one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R10 reset req_ready", {31'd0, req_ready}, 32'd1);
    chk(bus_cyc === 1'b0, "R10 reset bus_cyc", {31'd0, bus_cyc}, 32'd0);
    chk(rsp_valid === 1'b0, "R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: even word write and read back
    do_req(16'h0000, 16'h0500, 1, 1, 16'h1234);
    do_req(16'h0000, 16'h0500, 1, 0, 16'h0000);
    chk(rsp_rdata === 16'h1234, "R2 even word read back", {16'd0, rsp_rdata}, 32'h1234);
    // R3: odd word write, then read
    do_req(16'h0050, 16'h0021, 1, 1, 16'hF520);
    do_req(16'h0000, 16'h0521, 1, 0, 16'h0000);
    // R4: byte writes on both lanes, then reads
    do_req(16'h0100, 16'h0002, 0, 1, 16'hAA5C);
    do_req(16'h0100, 16'h0003, 0, 1, 16'h77C3);
    do_req(16'h0100, 16'h0002, 1, 0, 16'h0000);
    do_req(16'h0100, 16'h0003, 0, 0, 16'h0000);
    // R9: wrap of the segment sum and of the second cycle
    do_req(16'hFFFF, 16'h0020, 1, 1, 16'hBEEF);
    do_req(16'hFFFF, 16'h000F, 1, 1, 16'hC1A0);
    do_req(16'hFFFF, 16'h000F, 1, 0, 16'h0000);
    do_req(16'hF000, 16'hFFFF, 0, 0, 16'h0000);

    for (int k = 0; k < 400; k++) begin
      logic [15:0] s, o;
      s = ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom_range(0, 16'h00FF));
      o = 16'($urandom_range(0, 16'h00FF));
      do_req(s, o, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 16'($urandom()));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule